// File: doc/BRIEF.md
# Bit-6 Channel Swizzle Unit

This block rewrites bit 6 of a physical address so that processor accesses to tiled surfaces land on the same memory channel that the graphics engine would use. A dual-channel interleaved memory controller swaps channels when bit 6 flips. For tiled data it also swaps when certain higher bits flip. The unit XORs a chosen set of those higher bits (9, 10, 11 or 17) into bit 6. All other address bits pass through unchanged.

The set of bits is a swizzle mode. The unit derives one mode for X-tiled surfaces and one for Y-tiled surfaces from a memory configuration word. It samples that word into a mode register when the configuration is loaded. The address path is a zero-latency valid/ready stream with no storage:
- `out_valid` follows `in_valid` in the same cycle.
- `in_ready` follows `out_ready` in the same cycle.
- While `out_ready` is low, the upstream side must hold its address and tiling kind steady.

Untiled accesses are never modified.

Configuration word fields (SIZE_W = 8 by default):
- bits [1:0]: channel arrangement. 0 = single channel, 1 = dual asymmetric, 2 = dual interleaved, 3 = undefined.
- bit 2: processor channel XOR disabled.
- bit 3: processor channel XOR source. 0 = bit 11, 1 = bit 17.
- bit 4: layout unresolved.
- bits [7:5]: reserved.
- bits [8 +: SIZE_W]: populated size of channel A.
- bits [8+SIZE_W +: SIZE_W]: populated size of channel B.

Mode codes: 0 = NONE, 1 = B9, 2 = B9_10, 3 = B9_11, 4 = B9_10_11, 5 = B9_17, 6 = B9_10_17, 7 = UNKNOWN. Code 7 is used only internally and is never reported. Tiling kind codes: 1 = X, 2 = Y, 0 and 3 = untiled.

Top module: `bit6_swizzle_unit`

## Requirements
- R1: After reset, both reported modes are 0 (NONE) and `pin_pages` is 0.
- R2: An interleaved arrangement (code 2) with XOR disabled and equal channel sizes gives X mode 2 (B9_10) and Y mode 1 (B9), with `pin_pages` 0.
- R3: Interleaved, XOR enabled with bit 11 as source, and equal sizes gives X mode 4 (B9_10_11) and Y mode 3 (B9_11).
- R4: Interleaved, XOR enabled with bit 17 as source, and equal sizes gives X mode 6 (B9_10_17) and Y mode 5 (B9_17).
- R5: Single-channel (code 0) and asymmetric (code 1) arrangements give mode 0 for both tiling kinds, with `pin_pages` 0.
- R6: An interleaved arrangement whose two channel sizes differ gives mode 0 for both tiling kinds.
- R7: Any of the following makes the configuration unknown: a word of all ones, the unresolved flag (bit 4) set, or arrangement code 3. An unknown configuration reports mode 0 for both kinds and sets `pin_pages` to 1.
- R8: A configuration sampled at a clock edge with `cfg_load` high is visible on `mode_x`, `mode_y` and `pin_pages` right after that edge. Without `cfg_load`, those outputs hold even if `cfg_word` changes.
- R9: For X (Y) tiling, `out_addr` equals `in_addr` except for bit 6. Bit 6 equals `in_addr[6]` XOR the address bits named by the reported X (Y) mode. This is combinational in the same cycle.
- R10: With tiling code 0 or 3, `out_addr` equals `in_addr` whatever the mode.
- R11: `out_valid` equals `in_valid` and `in_ready` equals `out_ready` in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_word | input | 8+2*SIZE_W | Memory configuration word |
| cfg_load | input | 1 | Sample `cfg_word` into the mode register |
| mode_x | output | 3 | Reported swizzle mode for X tiling |
| mode_y | output | 3 | Reported swizzle mode for Y tiling |
| pin_pages | output | 1 | Configuration unknown; backing pages must stay put |
| in_valid | input | 1 | Address stream valid |
| in_ready | output | 1 | Address stream ready |
| in_addr | input | ADDR_W | Physical address in |
| in_tile | input | 2 | Tiling kind: 1 X, 2 Y, others untiled |
| out_valid | output | 1 | Swizzled stream valid |
| out_ready | input | 1 | Downstream ready |
| out_addr | output | ADDR_W | Swizzled address |

## Verification
The address path and the handshake are combinational. The bench therefore drives them one time unit after a rising edge and compares them at the following falling edge of the same cycle.

Mode outputs change only on the edge that samples `cfg_load`. A behavioural model in the bench updates on that same edge. Every falling edge compares the model against the design, so a mode that arrives a cycle early or late is caught. A directed check also confirms that the old mode is still present while `cfg_load` is high but not yet sampled.

// File: rtl/swz_pkg.sv
package swz_pkg;

  typedef enum logic [2:0] {
    SWZ_NONE     = 3'd0,
    SWZ_B9       = 3'd1,
    SWZ_B9_10    = 3'd2,
    SWZ_B9_11    = 3'd3,
    SWZ_B9_10_11 = 3'd4,
    SWZ_B9_17    = 3'd5,
    SWZ_B9_10_17 = 3'd6,
    SWZ_UNKNOWN  = 3'd7
  } swz_mode_e;

  localparam logic [1:0] TILE_X = 2'b01;
  localparam logic [1:0] TILE_Y = 2'b10;

  localparam logic [1:0] CHAN_SINGLE = 2'd0;
  localparam logic [1:0] CHAN_ASYM   = 2'd1;
  localparam logic [1:0] CHAN_ILV    = 2'd2;
  localparam logic [1:0] CHAN_RSVD   = 2'd3;

  localparam int BIT_SWZ  = 6;
  localparam int NUM_TAPS = 4;
  // tap index -> address bit position
  localparam int TAP_POS [NUM_TAPS] = '{9, 10, 11, 17};

  typedef logic [NUM_TAPS-1:0] tap_sel_t;

  // which higher address bits each mode folds into bit 6
  function automatic tap_sel_t mode_taps(swz_mode_e m);
    tap_sel_t s;
    case (m)
      SWZ_B9:       s = 4'b0001;
      SWZ_B9_10:    s = 4'b0011;
      SWZ_B9_11:    s = 4'b0101;
      SWZ_B9_10_11: s = 4'b0111;
      SWZ_B9_17:    s = 4'b1001;
      SWZ_B9_10_17: s = 4'b1011;
      default:      s = 4'b0000;
    endcase
    return s;
  endfunction

endpackage

// File: rtl/swz_cfg_decode.sv
module swz_cfg_decode
  import swz_pkg::*;
#(
  parameter int SIZE_W = 8
) (
  input  logic [8+2*SIZE_W-1:0] cfg_word,
  output swz_mode_e             dec_x,
  output swz_mode_e             dec_y,
  output logic                  dec_unknown
);

  localparam int F_XOFF  = 2;
  localparam int F_XHI   = 3;
  localparam int F_UNRES = 4;
  localparam int F_SZA   = 8;
  localparam int F_SZB   = 8 + SIZE_W;

  logic [1:0]        chan;
  logic [SIZE_W-1:0] size_a, size_b;
  logic              bad_read;

  assign chan     = cfg_word[1:0];
  assign size_a   = cfg_word[F_SZA +: SIZE_W];
  assign size_b   = cfg_word[F_SZB +: SIZE_W];
  assign bad_read = &cfg_word;

  always_comb begin
    dec_x       = SWZ_NONE;
    dec_y       = SWZ_NONE;
    dec_unknown = 1'b0;
    if (bad_read || cfg_word[F_UNRES] || chan == CHAN_RSVD) begin
      dec_x       = SWZ_UNKNOWN;
      dec_y       = SWZ_UNKNOWN;
      dec_unknown = 1'b1;
    end else if (chan == CHAN_ILV && size_a == size_b) begin
      if (cfg_word[F_XOFF]) begin
        dec_x = SWZ_B9_10;
        dec_y = SWZ_B9;
      end else if (!cfg_word[F_XHI]) begin
        dec_x = SWZ_B9_10_11;
        dec_y = SWZ_B9_11;
      end else begin
        dec_x = SWZ_B9_10_17;
        dec_y = SWZ_B9_17;
      end
    end
  end

  // Y tiling never folds bit 10 (R2, R3, R4)
  always_comb begin
    assert_y_no_b10_R2: assert (!mode_taps(dec_y)[1]);
  end

endmodule

// File: rtl/swz_mode_reg.sv
module swz_mode_reg
  import swz_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      load,
  input  swz_mode_e dec_x,
  input  swz_mode_e dec_y,
  input  logic      dec_unknown,
  output swz_mode_e mode_x,
  output swz_mode_e mode_y,
  output logic      pin_pages
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_x    <= SWZ_NONE;
      mode_y    <= SWZ_NONE;
      pin_pages <= 1'b0;
    end else if (load) begin
      if (dec_unknown) begin
        mode_x    <= SWZ_NONE;
        mode_y    <= SWZ_NONE;
        pin_pages <= 1'b1;
      end else begin
        mode_x    <= dec_x;
        mode_y    <= dec_y;
        pin_pages <= 1'b0;
      end
    end
  end

  assert_never_unknown_R7: assert property (@(posedge clk) disable iff (!rst_n)
    mode_x != SWZ_UNKNOWN && mode_y != SWZ_UNKNOWN);

  assert_pin_means_none_R7: assert property (@(posedge clk) disable iff (!rst_n)
    pin_pages |-> (mode_x == SWZ_NONE && mode_y == SWZ_NONE));

  assert_hold_without_load_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !load |=> ($stable(mode_x) && $stable(mode_y) && $stable(pin_pages)));

endmodule

// File: rtl/swz_xform.sv
module swz_xform
  import swz_pkg::*;
#(
  parameter int ADDR_W = 32   // must cover bit 17
) (
  input  logic [ADDR_W-1:0] in_addr,
  input  logic [1:0]        in_tile,
  input  swz_mode_e         mode_x,
  input  swz_mode_e         mode_y,
  output logic [ADDR_W-1:0] out_addr
);

  localparam logic [ADDR_W-1:0] SWZ_MASK = ADDR_W'(1) << BIT_SWZ;

  swz_mode_e     act_mode;
  tap_sel_t      sel;
  logic [NUM_TAPS-1:0] tap_bit;
  logic          flip;

  always_comb begin
    case (in_tile)
      TILE_X:  act_mode = mode_x;
      TILE_Y:  act_mode = mode_y;
      default: act_mode = SWZ_NONE;
    endcase
  end

  assign sel = mode_taps(act_mode);

  for (genvar g = 0; g < NUM_TAPS; g++) begin : g_tap
    assign tap_bit[g] = sel[g] & in_addr[TAP_POS[g]];
  end

  assign flip     = ^tap_bit;
  assign out_addr = flip ? (in_addr ^ SWZ_MASK) : in_addr;

  always_comb begin
    if (in_tile != TILE_X && in_tile != TILE_Y)
      assert_untiled_bypass_R10: assert (out_addr == in_addr);
    if ((in_tile == TILE_X && mode_x == SWZ_NONE) ||
        (in_tile == TILE_Y && mode_y == SWZ_NONE))
      assert_none_mode_identity_R9: assert (out_addr == in_addr);
  end

endmodule

// File: rtl/bit6_swizzle_unit.sv
module bit6_swizzle_unit
  import swz_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int SIZE_W = 8
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [8+2*SIZE_W-1:0] cfg_word,
  input  logic                  cfg_load,
  output logic [2:0]            mode_x,
  output logic [2:0]            mode_y,
  output logic                  pin_pages,
  input  logic                  in_valid,
  output logic                  in_ready,
  input  logic [ADDR_W-1:0]     in_addr,
  input  logic [1:0]            in_tile,
  output logic                  out_valid,
  input  logic                  out_ready,
  output logic [ADDR_W-1:0]     out_addr
);

  swz_mode_e dec_x, dec_y, reg_x, reg_y;
  logic      dec_unknown;

  swz_cfg_decode #(.SIZE_W(SIZE_W)) u_decode (
    .cfg_word    (cfg_word),
    .dec_x       (dec_x),
    .dec_y       (dec_y),
    .dec_unknown (dec_unknown)
  );

  swz_mode_reg u_mode (
    .clk         (clk),
    .rst_n       (rst_n),
    .load        (cfg_load),
    .dec_x       (dec_x),
    .dec_y       (dec_y),
    .dec_unknown (dec_unknown),
    .mode_x      (reg_x),
    .mode_y      (reg_y),
    .pin_pages   (pin_pages)
  );

  swz_xform #(.ADDR_W(ADDR_W)) u_xform (
    .in_addr  (in_addr),
    .in_tile  (in_tile),
    .mode_x   (reg_x),
    .mode_y   (reg_y),
    .out_addr (out_addr)
  );

  assign mode_x    = reg_x;
  assign mode_y    = reg_y;
  assign out_valid = in_valid;
  assign in_ready  = out_ready;

endmodule

// File: tb/test_bit6_swizzle_unit.sv
module test_bit6_swizzle_unit;

  localparam int CLK_PERIOD = 10;
  localparam int AW = 32;
  localparam int SW = 8;
  localparam int WDOG = 20000;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [23:0]   cfg_word = '0;
  logic          cfg_load = 1'b0;
  logic [2:0]    mode_x, mode_y;
  logic          pin_pages;
  logic          in_valid = 1'b0;
  logic          in_ready;
  logic [AW-1:0] in_addr = '0;
  logic [1:0]    in_tile = 2'd0;
  logic          out_valid;
  logic          out_ready = 1'b0;
  logic [AW-1:0] out_addr;

  int checks = 0;
  int fails = 0;
  int cyc = 0;
  bit done = 0;

  int ref_x = 0, ref_y = 0;
  bit ref_pin = 0;

  bit6_swizzle_unit #(.ADDR_W(AW), .SIZE_W(SW)) i_bit6_swizzle_unit (
    .clk(clk), .rst_n(rst_n), .cfg_word(cfg_word), .cfg_load(cfg_load),
    .mode_x(mode_x), .mode_y(mode_y), .pin_pages(pin_pages),
    .in_valid(in_valid), .in_ready(in_ready), .in_addr(in_addr),
    .in_tile(in_tile), .out_valid(out_valid), .out_ready(out_ready),
    .out_addr(out_addr)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h at t=%0t", req, act, exp, $time);
    end
  endtask

  function automatic logic [23:0] mk(input int chan, input bit xoff, input bit xhi,
                                     input bit unres, input int sa, input int sb);
    return {sb[7:0], sa[7:0], 3'b000, unres, xhi, xoff, chan[1:0]};
  endfunction

  task automatic ref_decode(input logic [23:0] w, output int ex, output int ey, output bit p);
    ex = 0; ey = 0; p = 0;
    if (w == 24'hFFFFFF || w[4] || w[1:0] == 2'd3) p = 1;
    else if (w[1:0] == 2'd2 && w[15:8] == w[23:16]) begin
      if (w[2])       begin ex = 2; ey = 1; end
      else if (!w[3]) begin ex = 4; ey = 3; end
      else            begin ex = 6; ey = 5; end
    end
  endtask

  function automatic bit fold(input int m, input logic [AW-1:0] a);
    case (m)
      1: return a[9];
      2: return a[9] ^ a[10];
      3: return a[9] ^ a[11];
      4: return a[9] ^ a[10] ^ a[11];
      5: return a[9] ^ a[17];
      6: return a[9] ^ a[10] ^ a[17];
      default: return 1'b0;
    endcase
  endfunction

  function automatic logic [AW-1:0] ref_addr(input logic [AW-1:0] a, input logic [1:0] t);
    logic [AW-1:0] r;
    r = a;
    if (t == 2'd1)      r[6] = a[6] ^ fold(ref_x, a);
    else if (t == 2'd2) r[6] = a[6] ^ fold(ref_y, a);
    return r;
  endfunction

  // behavioural reference of the mode register
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ref_x <= 0; ref_y <= 0; ref_pin <= 0;
    end else if (cfg_load) begin
      int ex, ey; bit p;
      ref_decode(cfg_word, ex, ey, p);
      ref_x <= ex; ref_y <= ey; ref_pin <= p;
    end
  end

  // per-cycle comparison, half a cycle after the edge
  always @(negedge clk) begin
    if (rst_n && !done) begin
      chk(mode_x == 3'(ref_x), "R8 mode_x", mode_x, ref_x);
      chk(mode_y == 3'(ref_y), "R8 mode_y", mode_y, ref_y);
      chk(pin_pages == ref_pin, "R8 pin_pages", pin_pages, ref_pin);
      chk(out_addr == ref_addr(in_addr, in_tile), "R9 out_addr", out_addr, ref_addr(in_addr, in_tile));
      chk(out_valid == in_valid, "R11 out_valid", out_valid, in_valid);
      chk(in_ready == out_ready, "R11 in_ready", in_ready, out_ready);
    end
  end

  task automatic finish_up;
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > WDOG && !done) begin
      chk(1'b0, "watchdog", cyc, WDOG);
      finish_up();
    end
  end

  task automatic load(input logic [23:0] w);
    @(posedge clk); #1;
    cfg_word = w; cfg_load = 1'b1;
    @(posedge clk); #1;
    cfg_load = 1'b0;
    @(negedge clk);
  endtask

  task automatic expect_modes(input string req, input int ex, input int ey, input bit p);
    chk(mode_x == 3'(ex), req, mode_x, ex);
    chk(mode_y == 3'(ey), req, mode_y, ey);
    chk(pin_pages == p, req, pin_pages, p);
  endtask

  task automatic drive(input logic [AW-1:0] a, input logic [1:0] t, input bit v, input bit r);
    @(posedge clk); #1;
    in_addr = a; in_tile = t; in_valid = v; out_ready = r;
    @(negedge clk);
  endtask

  task automatic stream(input int n);
    logic [31:0] lfsr;
    lfsr = 32'h1D2C3B4A;
    for (int i = 0; i < n; i++) begin
      lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
      drive(lfsr, 2'(i), lfsr[3], lfsr[7]);
    end
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk);
    expect_modes("R1 reset", 0, 0, 0);

    load(mk(2, 1, 0, 0, 8'h40, 8'h40));
    expect_modes("R2 interleaved base", 2, 1, 0);
    stream(40);

    load(mk(2, 0, 0, 0, 8'h33, 8'h33));
    expect_modes("R3 xor bit 11", 4, 3, 0);
    stream(40);

    load(mk(2, 0, 1, 0, 8'h80, 8'h80));
    expect_modes("R4 xor bit 17", 6, 5, 0);
    // R9: X uses bits 9,10,17; Y uses 9,17
    drive(32'h0002_0200, 2'd1, 1, 1);
    chk(out_addr == 32'h0002_0200, "R9 X two taps cancel", out_addr, 32'h0002_0200);
    drive(32'h0000_0600, 2'd1, 1, 1);
    chk(out_addr == 32'h0000_0600, "R9 X bits 9,10 cancel", out_addr, 32'h0000_0600);
    drive(32'h0000_0400, 2'd1, 1, 1);
    chk(out_addr == 32'h0000_0440, "R9 X bit 10 flips", out_addr, 32'h0000_0440);
    drive(32'h0000_0400, 2'd2, 1, 1);
    chk(out_addr == 32'h0000_0400, "R9 Y ignores bit 10", out_addr, 32'h0000_0400);
    drive(32'h0002_0040, 2'd2, 1, 1);
    chk(out_addr == 32'h0002_0000, "R9 Y bit 17 clears bit 6", out_addr, 32'h0002_0000);
    // R10: untiled codes bypass
    drive(32'h0000_0200, 2'd0, 1, 1);
    chk(out_addr == 32'h0000_0200, "R10 tile 0 bypass", out_addr, 32'h0000_0200);
    drive(32'h0000_0200, 2'd3, 1, 1);
    chk(out_addr == 32'h0000_0200, "R10 tile 3 bypass", out_addr, 32'h0000_0200);
    // R11: back-pressure passes straight through
    drive(32'h1234_5678, 2'd1, 1, 0);
    chk(in_ready == 1'b0 && out_valid == 1'b1, "R11 stalled", {in_ready, out_valid}, 2'b01);
    stream(40);

    // R8: word change without load leaves modes; pending load not yet visible
    @(posedge clk); #1 cfg_word = mk(0, 0, 0, 0, 0, 0);
    @(negedge clk);
    expect_modes("R8 no load holds", 6, 5, 0);
    @(posedge clk); #1 cfg_load = 1'b1;
    @(negedge clk);
    expect_modes("R8 before sampling edge", 6, 5, 0);
    @(posedge clk); #1 cfg_load = 1'b0;
    @(negedge clk);
    expect_modes("R5 single channel", 0, 0, 0);

    load(mk(1, 1, 0, 0, 8'h40, 8'h40));
    expect_modes("R5 asymmetric", 0, 0, 0);
    load(mk(2, 1, 0, 0, 8'h40, 8'h20));
    expect_modes("R6 unequal sizes", 0, 0, 0);
    drive(32'h0000_0600, 2'd1, 1, 1);
    chk(out_addr == 32'h0000_0600, "R6 no swizzle", out_addr, 32'h0000_0600);

    load(24'hFFFFFF);
    expect_modes("R7 all ones", 0, 0, 1);
    load(mk(2, 1, 0, 0, 8'h40, 8'h40));
    expect_modes("R2 clears pin", 2, 1, 0);
    load(mk(2, 1, 0, 1, 8'h40, 8'h40));
    expect_modes("R7 unresolved", 0, 0, 1);
    load(mk(3, 1, 0, 0, 8'h40, 8'h40));
    expect_modes("R7 undefined arrangement", 0, 0, 1);
    stream(20);

    finish_up();
  end

endmodule